// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter for a microcontroller peripheral bus. It has three operating modes. As a timer it counts the internal instruction cycle, which is one tick every four system clocks. As a synchronous counter it counts rising edges of an external input after a two-flop synchronizer. As an asynchronous counter it counts the same edges without the synchronizer. Each tick passes through a prescaler set to divide by 1, 2, 4 or 8. A run bit gates counting. A wrap from 0xFFFF to 0x0000 sets a sticky overflow flag. A pulse from a compare unit's special event trigger clears the count.

Software reaches the block over a plain 8-bit register bus with a 2-bit address. There is no handshake and no back-pressure. A write lands on the next rising clock edge. Read data is combinational from the address. A read has a side effect only on the low count byte in wide mode, and that side effect takes place at the clock edge of the read cycle. The register addresses are: 0 = count low byte, 1 = count high byte, 2 = control, 3 = flag.

The control register fields are: bit 0 run, bit 1 source select (1 = external), bit 2 synchronizer bypass (1 = asynchronous counting), bits 4:3 prescale code, and bit 7 wide mode. In wide mode the high byte goes through a buffer register, so that 16-bit reads and writes made over the 8-bit bus stay consistent.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the count, the control register (address 2) and the flag (address 3, bit 0) all read 0.
- R2: With run=1 and source select (control bit 1) = 0, the count advances once every 4 system clocks, divided further by the prescaler. Over 64 clocks of run, the count grows by 16 >> code.
- R3: With source select = 1, the count advances once per rising edge of the external input. A level held high, or a falling edge, adds nothing further.
- R4: The prescale code (control bits 4:3) values 0, 1, 2 and 3 divide the tick rate by 1, 2, 4 and 8. The first prescaled tick comes after that many input ticks.
- R5: With bypass (control bit 2) = 1, an external rise present before clock edge k is counted at edge k. With bypass = 0 it is counted two edges later, at edge k+2.
- R6: With run=0, the count and the prescaler hold, whatever the external input does.
- R7: An increment from 0xFFFF yields 0x0000 and sets the flag. The flag stays set until software writes 0 to address 3 bit 0. A wrap and a software clear in the same cycle leave the flag set.
- R8: A high pulse on evt_clear zeroes the count on the next edge. This takes priority over increments and over bus writes in the same cycle.
- R9: In wide mode (control bit 7 = 1), reading the low byte copies the live high byte into the buffer. Reading the high byte then returns the buffer, not the live value.
- R10: In wide mode, writing the high byte loads only the buffer and leaves the count unchanged. Writing the low byte loads {buffer, data} into the count in one cycle.
- R11: In byte mode (control bit 7 = 0), the high byte is read and written directly. A low-byte write keeps the live high byte.
- R12: Any write to address 0 or 1 restarts the prescaler's internal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_in | input | 1 | External count input, asynchronous to clk |
| evt_clear | input | 1 | Count clear from a compare unit's special event trigger |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ovf_flag | output | 1 | Overflow interrupt flag |

## Verification
The bench sweeps every prescale code, both with the internal source and with the external source in each synchronizer setting, and for two edge counts. This separates a wrong divide ratio from a wrong source selection or a missed edge. A single rise with one-edge resolution tells the raw path from the synchronized path by its latency. A long high pulse shows that only edges are counted. Staged byte accesses in wide and byte mode separate buffer behaviour from direct access. Coincident stimuli check the priorities: a wrap against a flag clear, a clear against a write, and a write against a partly filled prescaler.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  typedef struct packed {
    logic       wide;
    logic [1:0] spare;
    logic [1:0] psel;
    logic       bypass;
    logic       src_ext;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/pst_tick_src.sv
module pst_tick_src #(
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic src_ext,
  input  logic bypass,
  input  logic run,
  output logic tick
);
  logic [DIV_W-1:0]     div_q;
  logic [SYNC_STAGES:0] shq;
  logic int_tick, sync_edge, raw_edge;

  // free-running instruction-cycle divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
  assign int_tick = &div_q;

  // synchronizer chain plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shq[0] <= 1'b0;
    else        shq[0] <= ext_in;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shq[i] <= 1'b0;
      else        shq[i] <= shq[i-1];
    end
  end

  assign sync_edge = shq[SYNC_STAGES-1] & ~shq[SYNC_STAGES];
  assign raw_edge  = ext_in & ~shq[0];

  always_comb begin
    if (src_ext) tick = run & (bypass ? raw_edge : sync_edge);
    else         tick = run & int_tick;
  end
endmodule

// File: rtl/pst_prescaler.sv
module pst_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick_in,
  input  logic [PS_W-1:0] psel,
  output logic            tick_out
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;

  assign mask     = ~({PC_W{1'b1}} << psel);
  assign tick_out = tick_in & ((pc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (clr)     pc_q <= '0;
    else if (tick_in) pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/pst_core.sv
module pst_core #(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_clr,
  input  logic             inc,
  input  logic             wide,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             rd_lo,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [BUS_W-1:0] hbuf,
  output logic             ovf_set
);
  logic direct_hi;
  logic loaded;

  assign direct_hi = wr_hi & ~wide;
  assign loaded    = evt_clr | wr_lo | direct_hi;
  assign ovf_set   = inc & (&cnt) & ~loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (evt_clr)   cnt <= '0;
    else if (wr_lo)     cnt <= wide ? {hbuf, wdata} : {cnt[CNT_W-1:BUS_W], wdata};
    else if (direct_hi) cnt <= {wdata, cnt[BUS_W-1:0]};
    else if (inc)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hbuf <= '0;
    else if (wide && wr_hi)  hbuf <= wdata;
    else if (wide && rd_lo)  hbuf <= cnt[CNT_W-1:BUS_W];
  end
endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16 #(
  parameter int BUS_W       = 8,
  parameter int DIV_W       = 2,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_in,
  input  logic             evt_clear,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             ovf_flag
);
  import pst_pkg::*;
  localparam int CNT_W = 2 * BUS_W;

  ctrl_t            ctrl_q;
  logic             flag_q;
  logic             wr_lo, wr_hi, rd_lo, wr_ctrl, wr_flag;
  logic             raw_tick, inc;
  logic             ovf_set;
  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] hbuf;

  assign wr_lo   = bus_wr && bus_addr == ADDR_LO;
  assign wr_hi   = bus_wr && bus_addr == ADDR_HI;
  assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
  assign wr_flag = bus_wr && bus_addr == ADDR_FLAG;
  assign rd_lo   = bus_rd && bus_addr == ADDR_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
  end

  // a wrap in the same cycle as a software clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= ovf_set | (wr_flag ? bus_wdata[0] : flag_q);
  end

  pst_tick_src #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_in (ext_clk_in),
    .src_ext(ctrl_q.src_ext),
    .bypass (ctrl_q.bypass),
    .run    (ctrl_q.run),
    .tick   (raw_tick)
  );

  pst_prescaler #(.PS_W(PS_W)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wr_lo | wr_hi),
    .tick_in (raw_tick),
    .psel    (ctrl_q.psel[PS_W-1:0]),
    .tick_out(inc)
  );

  pst_core #(.BUS_W(BUS_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_clr(evt_clear),
    .inc    (inc),
    .wide   (ctrl_q.wide),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .rd_lo  (rd_lo),
    .wdata  (bus_wdata),
    .cnt    (cnt),
    .hbuf   (hbuf),
    .ovf_set(ovf_set)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_LO:   bus_rdata = cnt[BUS_W-1:0];
      ADDR_HI:   bus_rdata = ctrl_q.wide ? hbuf : cnt[CNT_W-1:BUS_W];
      ADDR_CTRL: bus_rdata = BUS_W'(ctrl_q);
      default:   bus_rdata = BUS_W'(flag_q);
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/pst_check.sv
module pst_check #(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             inc,
  input logic             run,
  input logic             evt_clear,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic             wr_flag,
  input logic             flag
);
  logic quiet;
  assign quiet = !evt_clear && !wr_lo && !wr_hi;

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> cnt == '0);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && inc |=> cnt == $past(cnt) + 1'b1);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && !run |=> $stable(cnt));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> run);

  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && inc && (&cnt) |=> flag && cnt == '0);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !wr_flag |=> flag);
endmodule

bind prescaled_timer16 pst_check #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt),
  .inc      (inc),
  .run      (ctrl_q.run),
  .evt_clear(evt_clear),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .wr_flag  (wr_flag),
  .flag     (flag_q)
);

// File: tb/prescaled_timer16_test.sv
`timescale 1ns/1ps
module prescaled_timer16_test;
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CT = 2'd2, A_FL = 2'd3;
  localparam logic [7:0] RUN = 8'h01, EXT = 8'h02, BYP = 8'h04, WIDE = 8'h80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       evt_clear = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ovf_flag;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prescaled_timer16 uut (
    .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .evt_clear(evt_clear),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr_reg(A_LO, v[7:0]);
    wr_reg(A_HI, v[15:8]);
  endtask

  task automatic get_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(A_LO, lo);
    rd_reg(A_HI, hi);
    v = {hi, lo};
  endtask

  task automatic pulse();
    ext_clk_in = 1'b1;
    @(negedge clk);
    ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    get_cnt(v);          chk("R1 count", v, 16'h0000);
    rd_reg(A_CT, b);     chk("R1 ctrl", {8'h0, b}, 16'h0000);
    rd_reg(A_FL, b);     chk("R1 flag", {8'h0, b}, 16'h0000);

    // R2/R4 internal source, every prescale code, 64 clocks of run
    for (int ps = 0; ps < 4; ps++) begin
      wr_reg(A_CT, 8'h00);
      set_cnt(16'h0000);
      wr_reg(A_CT, RUN | 8'(ps << 3));
      repeat (63) @(negedge clk);
      wr_reg(A_CT, 8'h00);
      get_cnt(v);
      chk($sformatf("R2 R4 internal ps=%0d", ps), v, 16'(16 >> ps));
    end

    // R3/R4/R5 external source sweep: sync mode, prescale code, edge count
    for (int sy = 0; sy < 2; sy++)
      for (int ps = 0; ps < 4; ps++)
        for (int k = 0; k < 2; k++) begin
          int n;
          n = (k == 0) ? 3 : 11;
          wr_reg(A_CT, 8'h00);
          set_cnt(16'h0000);
          wr_reg(A_CT, RUN | EXT | (sy == 0 ? BYP : 8'h00) | 8'(ps << 3));
          repeat (n) pulse();
          wr_reg(A_CT, 8'h00);
          get_cnt(v);
          chk($sformatf("R3 R4 R5 ext sync=%0d ps=%0d n=%0d", sy, ps, n), v, 16'(n >> ps));
        end

    // R3 long high level counts once
    set_cnt(16'h0000);
    wr_reg(A_CT, RUN | EXT);
    ext_clk_in = 1'b1;
    repeat (10) @(negedge clk);
    ext_clk_in = 1'b0;
    repeat (4) @(negedge clk);
    wr_reg(A_CT, 8'h00);
    get_cnt(v);          chk("R3 level held", v, 16'h0001);

    // R5 latency: raw counts at the first edge, synchronized two edges later
    set_cnt(16'h0000);
    wr_reg(A_CT, RUN | EXT | BYP);
    ext_clk_in = 1'b1;
    @(negedge clk);
    rd_reg(A_LO, b);     chk("R5 raw after 1 edge", {8'h0, b}, 16'h0001);
    ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    wr_reg(A_CT, 8'h00);
    set_cnt(16'h0000);
    wr_reg(A_CT, RUN | EXT);
    ext_clk_in = 1'b1;
    @(negedge clk);
    ext_clk_in = 1'b0;
    bus_addr = A_LO; #1;
    chk("R5 sync after 1 edge", {8'h0, bus_rdata}, 16'h0000);
    @(negedge clk); @(negedge clk);
    #1 chk("R5 sync after 3 edges", {8'h0, bus_rdata}, 16'h0001);
    @(negedge clk);

    // R6 run off holds the count
    wr_reg(A_CT, 8'h00);
    set_cnt(16'h0042);
    wr_reg(A_CT, EXT | BYP);
    repeat (3) pulse();
    get_cnt(v);          chk("R6 hold while off", v, 16'h0042);

    // R12 count write restarts the prescaler
    wr_reg(A_CT, 8'h00);
    set_cnt(16'h0000);
    wr_reg(A_CT, RUN | EXT | BYP | 8'h18);
    repeat (5) pulse();
    wr_reg(A_LO, 8'h10);
    repeat (7) pulse();
    wr_reg(A_CT, 8'h00);
    get_cnt(v);          chk("R12 seven after write", v, 16'h0010);
    wr_reg(A_CT, RUN | EXT | BYP | 8'h18);
    pulse();
    wr_reg(A_CT, 8'h00);
    get_cnt(v);          chk("R12 eighth after write", v, 16'h0011);

    // R7 wrap, sticky flag, software clear, coincident set wins
    set_cnt(16'hFFFE);
    wr_reg(A_CT, RUN | EXT | BYP);
    pulse();
    chk("R7 no flag at FFFF", {15'h0, ovf_flag}, 16'h0000);
    pulse();
    chk("R7 flag on wrap", {15'h0, ovf_flag}, 16'h0001);
    repeat (2) pulse();
    chk("R7 flag sticky", {15'h0, ovf_flag}, 16'h0001);
    wr_reg(A_FL, 8'h00);
    chk("R7 flag cleared", {15'h0, ovf_flag}, 16'h0000);
    wr_reg(A_CT, 8'h00);
    set_cnt(16'hFFFF);
    wr_reg(A_CT, RUN | EXT | BYP);
    ext_clk_in = 1'b1;
    bus_addr = A_FL; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 set beats clear", {15'h0, ovf_flag}, 16'h0001);
    wr_reg(A_CT, 8'h00);
    get_cnt(v);          chk("R7 wrapped to zero", v, 16'h0000);

    // R8 special event clear and its priority
    set_cnt(16'h0500);
    evt_clear = 1'b1;
    @(negedge clk);
    evt_clear = 1'b0;
    get_cnt(v);          chk("R8 clear", v, 16'h0000);
    set_cnt(16'h0500);
    evt_clear = 1'b1;
    wr_reg(A_LO, 8'h77);
    evt_clear = 1'b0;
    get_cnt(v);          chk("R8 clear beats write", v, 16'h0000);
    set_cnt(16'h0500);
    wr_reg(A_CT, RUN | EXT | BYP);
    evt_clear = 1'b1; ext_clk_in = 1'b1;
    @(negedge clk);
    evt_clear = 1'b0; ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    wr_reg(A_CT, 8'h00);
    get_cnt(v);          chk("R8 clear beats increment", v, 16'h0000);

    // R10 wide-mode writes
    set_cnt(16'h0000);
    wr_reg(A_CT, WIDE);
    wr_reg(A_HI, 8'hAB);
    wr_reg(A_CT, 8'h00);
    rd_reg(A_HI, b);     chk("R10 high write buffered only", {8'h0, b}, 16'h0000);
    wr_reg(A_CT, WIDE);
    wr_reg(A_HI, 8'h12);
    wr_reg(A_LO, 8'hFF);
    wr_reg(A_CT, 8'h00);
    get_cnt(v);          chk("R10 low write loads both", v, 16'h12FF);

    // R9 wide-mode reads
    wr_reg(A_CT, WIDE | RUN | EXT | BYP);
    rd_reg(A_LO, b);     chk("R9 low read", {8'h0, b}, 16'h00FF);
    pulse();
    rd_reg(A_HI, b);     chk("R9 high from buffer", {8'h0, b}, 16'h0012);

    // R11 byte-mode direct access
    wr_reg(A_CT, 8'h00);
    rd_reg(A_HI, b);     chk("R11 live high", {8'h0, b}, 16'h0013);
    wr_reg(A_HI, 8'h5A);
    get_cnt(v);          chk("R11 direct high write", v, 16'h5A00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule